// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block holds the settings of a frequency synthesizer. The settings are a 9-bit feedback count that sets the oscillator frequency (2 MHz per count), a 2-bit select for the post-divider, and a 3-bit select for the test-output mux. The settings can be written in two ways. The first is a serial port: a bit clock, a data bit and a load strobe. The second is a parallel port: the count and divider select on pins, plus a capture strobe. Both paths write one shared configuration register, and the parallel path wins when both write at once.

All port inputs are treated as asynchronous. Each one passes through a synchronizer clocked by the system clock, and edges are found after that. The block outputs the latched settings and the decoded post-divide ratio. It also raises a flag whenever the latched count lies outside the range where the loop can lock.

Top module: `synth_cfg_port`

## Requirements
- R1: After reset the outputs are count 0, divider select 0, test select 0, loaded flag 0, and the unlock flag is 1.
- R2: Each rising edge of the serial bit clock shifts the serial data bit into a 14-bit frame. The first bit sent ends up in frame bit 13. The frame is packed as {test[2:0], div[1:0], count[8:0]}, so the last bit sent is count bit 0.
- R3: A falling edge of the serial load strobe copies the frame into the configuration, but only while the parallel strobe is high. When the parallel strobe is low, that falling edge is ignored.
- R4: A rising edge of the parallel strobe captures the count and divider pins while the serial strobe is low, and leaves the test select unchanged. While the serial strobe is high, that rising edge is ignored.
- R5: If a serial copy and a parallel capture occur in the same cycle, the parallel pin values are stored and the test select keeps its previous value.
- R6: The divider select maps to the ratio output as follows: 00 gives 2, 01 gives 4, 10 gives 8, 11 gives 16.
- R7: The unlock flag is 1 exactly when the latched count is below 200 or above 400.
- R8: The loaded flag goes to 1 on the first capture or copy and stays at 1 until reset.
- R9: When more than 14 bits are shifted, only the last 14 bits are kept in the frame.
- R10: Shifting and strobe edges that cause no capture or copy leave the configuration unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous) |
| ser_data_i | input | 1 | Serial data bit |
| ser_load_i | input | 1 | Serial load strobe; its falling edge copies the frame |
| par_load_i | input | 1 | Parallel strobe; its rising edge captures the pins |
| par_m_i | input | 9 | Parallel feedback count |
| par_n_i | input | 2 | Parallel divider select |
| cfg_m_o | output | 9 | Latched feedback count |
| cfg_n_o | output | 2 | Latched divider select |
| cfg_t_o | output | 3 | Latched test select |
| div_ratio_o | output | 5 | Decoded post-divide ratio |
| unlock_o | output | 1 | Latched count is outside 200..400 |
| cfg_loaded_o | output | 1 | At least one configuration write since reset |

## Verification
Both write paths can fire in the same cycle. This happens when the serial strobe falls and the parallel strobe rises at the same moment: the serial condition sees the parallel strobe high, and the parallel condition sees the serial strobe low. The bench provokes this case by changing both strobes together, with a different frame already waiting in the shift register. It then checks that the pin values were stored and that the test select kept its earlier value. A later serial copy then shows that the waiting frame was not lost.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int unsigned M_W     = 9;
  localparam int unsigned N_W     = 2;
  localparam int unsigned T_W     = 3;
  localparam int unsigned FRAME_W = T_W + N_W + M_W;
  localparam int unsigned RATIO_W = (1 << N_W) + 1;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;

  // Post-divide ratio: two raised to (select + 1)
  function automatic logic [RATIO_W-1:0] ratio_of(input logic [N_W-1:0] sel);
    logic [RATIO_W-1:0] r;
    r = RATIO_W'(2);
    return r << sel;
  endfunction

  // Count outside the lockable window
  function automatic logic m_unlockable(input logic [M_W-1:0] m,
                                        input int unsigned lo,
                                        input int unsigned hi);
    return (32'(m) < lo) || (32'(m) > hi);
  endfunction

  function automatic cfg_t unpack_frame(input logic [FRAME_W-1:0] f);
    return cfg_t'(f);
  endfunction
endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] pipe_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= '0;
      prev_q <= '0;
    end else begin
      pipe_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign level_o = pipe_q[STAGES-1];

  for (genvar g = 0; g < W; g++) begin : g_edge
    assign rise_o[g] =  level_o[g] & ~prev_q[g];
    assign fall_o[g] = ~level_o[g] &  prev_q[g];
  end
endmodule

// File: rtl/synth_cfg_shifter.sv
module synth_cfg_shifter #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] frame_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       frame_o <= '0;
    else if (shift_i) frame_o <= {frame_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/synth_cfg_store.sv
module synth_cfg_store
  import synth_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               par_cap_i,
  input  logic               ser_latch_i,
  input  logic [M_W-1:0]     par_m_i,
  input  logic [N_W-1:0]     par_n_i,
  input  logic [FRAME_W-1:0] frame_i,
  output cfg_t               cfg_o,
  output logic               loaded_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o    <= '0;
      loaded_o <= 1'b0;
    end else if (par_cap_i) begin
      cfg_o.m  <= par_m_i;
      cfg_o.n  <= par_n_i;
      loaded_o <= 1'b1;
    end else if (ser_latch_i) begin
      cfg_o    <= unpack_frame(frame_i);
      loaded_o <= 1'b1;
    end
  end
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
  import synth_cfg_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned LOCK_M_MIN  = 200,
  parameter int unsigned LOCK_M_MAX  = 400
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk_i,
  input  logic               ser_data_i,
  input  logic               ser_load_i,
  input  logic               par_load_i,
  input  logic [M_W-1:0]     par_m_i,
  input  logic [N_W-1:0]     par_n_i,
  output logic [M_W-1:0]     cfg_m_o,
  output logic [N_W-1:0]     cfg_n_o,
  output logic [T_W-1:0]     cfg_t_o,
  output logic [RATIO_W-1:0] div_ratio_o,
  output logic               unlock_o,
  output logic               cfg_loaded_o
);
  localparam int CTL_W     = 4;
  localparam int IDX_SCLK  = 0;
  localparam int IDX_SDATA = 1;
  localparam int IDX_SLOAD = 2;
  localparam int IDX_PLOAD = 3;

  logic [CTL_W-1:0]   ctl_lvl, ctl_rise, ctl_fall;
  logic [FRAME_W-1:0] frame_q;
  cfg_t               cfg_q;

  // Named internal events, used by the bound checker
  logic shift_ev, ser_latch_ev, par_cap_ev;

  synth_cfg_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({par_load_i, ser_load_i, ser_data_i, ser_clk_i}),
    .level_o (ctl_lvl),
    .rise_o  (ctl_rise),
    .fall_o  (ctl_fall)
  );

  assign shift_ev     = ctl_rise[IDX_SCLK];
  assign ser_latch_ev = ctl_fall[IDX_SLOAD] &  ctl_lvl[IDX_PLOAD];
  assign par_cap_ev   = ctl_rise[IDX_PLOAD] & ~ctl_lvl[IDX_SLOAD];

  synth_cfg_shifter #(.W(FRAME_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (shift_ev),
    .bit_i   (ctl_lvl[IDX_SDATA]),
    .frame_o (frame_q)
  );

  synth_cfg_store u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .par_cap_i   (par_cap_ev),
    .ser_latch_i (ser_latch_ev),
    .par_m_i     (par_m_i),
    .par_n_i     (par_n_i),
    .frame_i     (frame_q),
    .cfg_o       (cfg_q),
    .loaded_o    (cfg_loaded_o)
  );

  assign cfg_m_o     = cfg_q.m;
  assign cfg_n_o     = cfg_q.n;
  assign cfg_t_o     = cfg_q.t;
  assign div_ratio_o = ratio_of(cfg_q.n);
  assign unlock_o    = m_unlockable(cfg_q.m, LOCK_M_MIN, LOCK_M_MAX);
endmodule

// File: rtl/synth_cfg_checker.sv
module synth_cfg_checker
  import synth_cfg_pkg::*;
#(
  parameter int unsigned LO = 200,
  parameter int unsigned HI = 400
) (
  input logic               clk,
  input logic               rst_n,
  input logic               shift_ev,
  input logic               ser_latch_ev,
  input logic               par_cap_ev,
  input logic [M_W-1:0]     par_m_i,
  input logic [N_W-1:0]     par_n_i,
  input logic [FRAME_W-1:0] frame_q,
  input logic [M_W-1:0]     cfg_m_o,
  input logic [N_W-1:0]     cfg_n_o,
  input logic [T_W-1:0]     cfg_t_o,
  input logic [RATIO_W-1:0] div_ratio_o,
  input logic               unlock_o,
  input logic               cfg_loaded_o
);
  p_unloaded_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_loaded_o |-> (cfg_m_o == '0 && cfg_n_o == '0 && cfg_t_o == '0));

  p_shift_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> frame_q[FRAME_W-1:1] == $past(frame_q[FRAME_W-2:0]));

  p_serial_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_latch_ev && !par_cap_ev) |=> {cfg_t_o, cfg_n_o, cfg_m_o} == $past(frame_q));

  // covers R5 as well: the parallel values win whatever the serial side does
  p_parallel_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    par_cap_ev |=> (cfg_m_o == $past(par_m_i) && cfg_n_o == $past(par_n_i)
                    && cfg_t_o == $past(cfg_t_o)));

  p_ratio_single_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(div_ratio_o) == 1 && !div_ratio_o[0]);

  p_window_locks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cfg_m_o) >= LO && 32'(cfg_m_o) <= HI) |-> !unlock_o);

  p_low_count_unlocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cfg_m_o) < LO) |-> unlock_o);

  p_loaded_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_loaded_o |=> cfg_loaded_o);

  p_hold_without_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_latch_ev || par_cap_ev) |=> $stable({cfg_t_o, cfg_n_o, cfg_m_o}));
endmodule

bind synth_cfg_port synth_cfg_checker #(.LO(LOCK_M_MIN), .HI(LOCK_M_MAX)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .shift_ev     (shift_ev),
  .ser_latch_ev (ser_latch_ev),
  .par_cap_ev   (par_cap_ev),
  .par_m_i      (par_m_i),
  .par_n_i      (par_n_i),
  .frame_q      (frame_q),
  .cfg_m_o      (cfg_m_o),
  .cfg_n_o      (cfg_n_o),
  .cfg_t_o      (cfg_t_o),
  .div_ratio_o  (div_ratio_o),
  .unlock_o     (unlock_o),
  .cfg_loaded_o (cfg_loaded_o)
);

// File: tb/test_synth_cfg_port.sv
module test_synth_cfg_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0, par_load = 1'b0;
  logic [8:0] par_m = '0;
  logic [1:0] par_n = '0;
  logic [8:0] cfg_m;
  logic [1:0] cfg_n;
  logic [2:0] cfg_t;
  logic [4:0] ratio;
  logic unlock, loaded;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  synth_cfg_port i_synth_cfg_port (
    .clk(clk), .rst_n(rst_n),
    .ser_clk_i(ser_clk), .ser_data_i(ser_data), .ser_load_i(ser_load),
    .par_load_i(par_load), .par_m_i(par_m), .par_n_i(par_n),
    .cfg_m_o(cfg_m), .cfg_n_o(cfg_n), .cfg_t_o(cfg_t),
    .div_ratio_o(ratio), .unlock_o(unlock), .cfg_loaded_o(loaded)
  );

  typedef struct {
    int m; int n; int t; int ld; string req;
  } exp_t;
  exp_t sb_q[$];
  event chk_ev;

  function automatic int bench_ratio(int n);
    case (n)
      0: return 2;
      1: return 4;
      2: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic int bench_unlock(int m);
    return (m >= 200 && m <= 400) ? 0 : 1;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares them with the outputs
  initial begin
    exp_t e;
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        chk(e.req, "count",  int'(cfg_m),  e.m);
        chk(e.req, "div",    int'(cfg_n),  e.n);
        chk(e.req, "test",   int'(cfg_t),  e.t);
        chk(e.req, "loaded", int'(loaded), e.ld);
        chk({e.req, "/R6"}, "ratio",  int'(ratio),  bench_ratio(e.n));
        chk({e.req, "/R7"}, "unlock", int'(unlock), bench_unlock(e.m));
      end
    end
  end

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  // Driver side: push the expectation and let the monitor compare
  task automatic expect_cfg(int m, int n, int t, int ld, string req);
    exp_t e;
    settle();
    e.m = m; e.n = n; e.t = t; e.ld = ld; e.req = req;
    sb_q.push_back(e);
    ->chk_ev;
    #1;
  endtask

  task automatic drive_bit(logic b);
    @(negedge clk) ser_data = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (3) @(negedge clk);
    ser_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_frame(logic [13:0] f);
    for (int i = 13; i >= 0; i--) drive_bit(f[i]);
  endtask

  task automatic set_lines(logic sl, logic pl);
    @(negedge clk);
    ser_load = sl;
    par_load = pl;
    settle();
  endtask

  task automatic par_write(int m, int n);
    @(negedge clk);
    par_m = 9'(m);
    par_n = 2'(n);
    set_lines(1'b0, 1'b0);
    set_lines(1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_cfg(0, 0, 0, 0, "R1");

    // R4 ignored: parallel rising edge while serial strobe is high
    set_lines(1'b1, 1'b0);
    par_m = 9'd123;
    par_n = 2'd1;
    set_lines(1'b1, 1'b1);
    expect_cfg(0, 0, 0, 0, "R4-ignore");

    // R2/R3 serial frame {t=5, n=2, m=300}, copied on serial strobe fall
    send_frame({3'd5, 2'd2, 9'd300});
    set_lines(1'b0, 1'b1);
    expect_cfg(300, 2, 5, 1, "R2/R3");

    // R10 shifting alone changes nothing
    set_lines(1'b1, 1'b1);
    send_frame({3'd1, 2'd3, 9'd77});
    expect_cfg(300, 2, 5, 1, "R10");

    // R3 ignored: serial strobe falls while the parallel strobe is low
    set_lines(1'b1, 1'b0);
    set_lines(1'b0, 1'b0);
    expect_cfg(300, 2, 5, 1, "R3-ignore");

    // R4 parallel capture keeps the test select; R7 boundaries
    par_write(199, 3);
    expect_cfg(199, 3, 5, 1, "R4 m=199");
    par_write(200, 0);
    expect_cfg(200, 0, 5, 1, "R7 m=200");
    par_write(400, 1);
    expect_cfg(400, 1, 5, 1, "R7 m=400");
    par_write(401, 2);
    expect_cfg(401, 2, 5, 1, "R7 m=401");
    par_write(511, 3);
    expect_cfg(511, 3, 5, 1, "R7 m=511");

    // R9 overlong stream: only the last 14 bits count
    set_lines(1'b1, 1'b1);
    for (int i = 0; i < 6; i++) drive_bit(1'b1);
    send_frame({3'd3, 2'd1, 9'd250});
    set_lines(1'b0, 1'b1);
    expect_cfg(250, 1, 3, 1, "R9");

    // R5 both writes in one cycle: parallel values win, test select kept
    set_lines(1'b1, 1'b1);
    send_frame({3'd6, 2'd0, 9'd350});
    set_lines(1'b1, 1'b0);
    @(negedge clk);
    par_m = 9'd222;
    par_n = 2'd1;
    set_lines(1'b0, 1'b1);
    expect_cfg(222, 1, 3, 1, "R5");

    // R8 loaded stays set; the waiting frame is still there (R2)
    set_lines(1'b1, 1'b1);
    set_lines(1'b0, 1'b1);
    expect_cfg(350, 0, 6, 1, "R8/R2");

    settle();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule